// File: doc/BRIEF.md
# Carrier Loop Error-Source Handover

This block closes a carrier-recovery loop around a phase-accumulator NCO and hands the loop from a cold-start error source to a fine-tracking error source. The acquisition error comes from a non-data-aided discriminator and arrives on every sample clock. The tracking error comes from a decision-directed discriminator, the imaginary part of the recovered symbol times the conjugate of its sliced decision, divided by the symbol magnitude. It arrives once per symbol, marked by a strobe. The tracking error is computed upstream and only consumed here. Both sources drive one proportional-integral (type-2) loop filter, so a constant frequency offset is driven to zero steady-state error. The filter output is the NCO frequency word.

A lock detector compares a signed lock metric against a threshold and counts consecutive samples above it. The switch from acquisition to tracking is opt-in. It happens only when the auto-switch enable is set, the lock condition has been held long enough, and the symbol-timing recovery reports itself settled, all in the same sample. Only the error selection changes at the switch. The integrator, the frequency word and the phase accumulator keep their values. Tracking lasts until reset or until the enable is cleared.

The NCO phase accumulator is 32 bits wide. Its top six bits select a de-rotation phasor from a quarter-wave sine table.

Top module: `carrier_handover`

## Requirements
- R1: While `rst` is high at a clock edge, the phase word clears to 0, the frequency word and the integrator load `init_freq`, `locked_o` goes low and `track_o` goes low (acquisition).
- R2: On every clock edge out of reset, the phase word advances by the frequency word held before that edge, modulo 2^32.
- R3: In acquisition, every edge updates the loop with `nda_err`. With `e` the error sign-extended to 32 bits, the integrator becomes I' = I + (e << `ki_shift`). The frequency word becomes I' + (e << `kp_shift`). All sums wrap modulo 2^32.
- R4: `locked_o` is high once at least H consecutive edges have seen `lock_metric` > `lock_thresh` (signed compare), where H = `hold_len`, and a value of 0 counts as 1. One edge with the metric at or below the threshold drops `locked_o` low right after that edge.
- R5: While `auto_en` is low, the loop stays in acquisition (`track_o` low after every edge), regardless of lock and timing.
- R6: `track_o` rises right after an edge where `track_o` was low and `auto_en`, `locked_o` and `timing_ok` were all high. It never rises otherwise.
- R7: In tracking, the loop updates with the R3 equations using `dd_err`, and only on edges where `dd_stb` is high. `nda_err` has no effect. Between strobes the frequency word holds.
- R8: The switch to tracking leaves the integrator, the frequency word and the phase continuous. The switching edge applies a normal acquisition update, and tracking continues from that state.
- R9: Once tracking, the block stays in tracking when lock is lost or `timing_ok` drops. It returns to acquisition right after an edge with `auto_en` low.
- R10: The phasor is `rot_re` = cos(t) and `rot_im` = -sin(t), scaled by 32767 and within 4 LSB. Here t = (k + 0.5)·2π/64 and k is phase bits [31:26].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Enables the automatic switch to tracking |
| timing_ok | input | 1 | Symbol timing recovery settled |
| nda_err | input | 16 | Signed acquisition phase error, one per sample |
| lock_metric | input | 16 | Signed lock metric |
| lock_thresh | input | 16 | Signed lock threshold |
| hold_len | input | 16 | Consecutive above-threshold samples required |
| dd_err | input | 16 | Signed decision-directed phase error |
| dd_stb | input | 1 | `dd_err` valid (one per symbol) |
| kp_shift | input | 5 | Proportional gain as a left shift |
| ki_shift | input | 5 | Integral gain as a left shift |
| init_freq | input | 32 | Frequency word loaded at reset |
| phase_o | output | 32 | NCO phase accumulator |
| freq_o | output | 32 | NCO frequency word (loop filter output) |
| rot_re | output | 16 | Signed de-rotation phasor, real part |
| rot_im | output | 16 | Signed de-rotation phasor, imaginary part |
| locked_o | output | 1 | Lock hold reached |
| track_o | output | 1 | 1 = tracking source selected, 0 = acquisition |

## Verification
A wrong integrator or frequency word shows up in `freq_o` on the edge after the faulty update, and in `phase_o` one edge later, because every phase step adds the held frequency word. A wrong lock count or mode bit shows up on `locked_o` or `track_o` on the very next edge. A wrong mode bit also changes which error moves `freq_o` from then on, so ignored acquisition errors during tracking are caught in the frequency word between strobes. A wrong table entry or quadrant fold shows up in the phasor as soon as the phase word enters that sixty-fourth of a turn.

// File: rtl/carrier_ho_pkg.sv
package carrier_ho_pkg;

    localparam int ERR_W   = 16;
    localparam int PHASE_W = 32;
    localparam int HOLD_W  = 16;
    localparam int LUT_W   = 6;     // phase bits that address the phasor table
    localparam int AMP_W   = 16;

    typedef enum logic {
        MODE_ACQ = 1'b0,
        MODE_TRK = 1'b1
    } loop_mode_e;

    // one loop-filter update request
    typedef struct packed {
        logic                    valid;
        logic signed [ERR_W-1:0] err;
    } err_sample_t;

    // sine over the first quadrant, sampled at bin centres: round(32767*sin((k+0.5)*pi/32))
    function automatic logic signed [AMP_W-1:0] quarter_sine(input logic [3:0] k);
        logic signed [AMP_W-1:0] v;
        case (k)
            4'd0:  v = 16'sd1608;
            4'd1:  v = 16'sd4808;
            4'd2:  v = 16'sd7962;
            4'd3:  v = 16'sd11039;
            4'd4:  v = 16'sd14010;
            4'd5:  v = 16'sd16846;
            4'd6:  v = 16'sd19519;
            4'd7:  v = 16'sd22005;
            4'd8:  v = 16'sd24279;
            4'd9:  v = 16'sd26319;
            4'd10: v = 16'sd28105;
            4'd11: v = 16'sd29621;
            4'd12: v = 16'sd30852;
            4'd13: v = 16'sd31785;
            4'd14: v = 16'sd32412;
            default: v = 16'sd32728;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ho_lock_detect.sv
module ho_lock_detect
    import carrier_ho_pkg::*;
#(
    parameter int EW = ERR_W,
    parameter int HW = HOLD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [EW-1:0] metric,
    input  logic signed [EW-1:0] thresh,
    input  logic        [HW-1:0] hold_len,
    output logic                 locked
);
    logic [HW-1:0] run_q;
    logic [HW-1:0] need;
    logic          above;

    assign need   = (hold_len == '0) ? HW'(1) : hold_len;
    assign above  = metric > thresh;
    assign locked = run_q >= need;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!above)
            run_q <= '0;
        else if (run_q < need)
            run_q <= run_q + HW'(1);
    end

    // R4: a single non-above sample drops lock on the next cycle
    assert_below_clears_R4: assert property (@(posedge clk) disable iff (rst)
        !(metric > thresh) |=> !locked);

    // R4: lock can only appear after an above-threshold sample
    assert_lock_needs_above_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(metric > thresh));
endmodule

// File: rtl/ho_mode_ctrl.sv
module ho_mode_ctrl
    import carrier_ho_pkg::*;
#(
    parameter int EW = ERR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 auto_en,
    input  logic                 locked,
    input  logic                 timing_ok,
    input  logic signed [EW-1:0] nda_err,
    input  logic signed [EW-1:0] dd_err,
    input  logic                 dd_stb,
    output loop_mode_e           mode,
    output err_sample_t          upd
);
    loop_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_ACQ;
        end else begin
            case (mode_q)
                MODE_ACQ: if (auto_en && locked && timing_ok) mode_q <= MODE_TRK;
                default:  if (!auto_en)                       mode_q <= MODE_ACQ;
            endcase
        end
    end

    always_comb begin
        if (mode_q == MODE_ACQ) begin
            upd.valid = 1'b1;
            upd.err   = nda_err;
        end else begin
            upd.valid = dd_stb;
            upd.err   = dd_err;
        end
    end

    assign mode = mode_q;

    // R5: with the switch disabled the loop is in acquisition after every edge
    assert_disabled_stays_acq_R5: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> (mode == MODE_ACQ));

    // R6: entering tracking needs enable, lock and settled timing together
    assert_handover_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mode == MODE_TRK) |-> $past(auto_en && locked && timing_ok));

    // R9: tracking is not abandoned while the enable stays set
    assert_track_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TRK && auto_en) |=> (mode == MODE_TRK));
endmodule

// File: rtl/ho_loop_filter.sv
module ho_loop_filter
    import carrier_ho_pkg::*;
#(
    parameter int EW = ERR_W,
    parameter int PW = PHASE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  err_sample_t                   upd,
    input  logic [$clog2(PW)-1:0]         kp_shift,
    input  logic [$clog2(PW)-1:0]         ki_shift,
    input  logic [PW-1:0]                 init_freq,
    output logic [PW-1:0]                 freq_word
);
    logic [PW-1:0] integ_q, ctrl_q;
    logic [PW-1:0] e_ext, integ_n, prop;

    assign e_ext   = {{(PW-EW){upd.err[EW-1]}}, upd.err};
    assign integ_n = integ_q + (e_ext << ki_shift);
    assign prop    = e_ext << kp_shift;

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= init_freq;
            ctrl_q  <= init_freq;
        end else if (upd.valid) begin
            integ_q <= integ_n;
            ctrl_q  <= integ_n + prop;
        end
    end

    assign freq_word = ctrl_q;

    // R7: the frequency word moves only on a loop update
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !upd.valid |=> $stable(freq_word));
endmodule

// File: rtl/ho_nco.sv
module ho_nco
    import carrier_ho_pkg::*;
#(
    parameter int PW = PHASE_W,
    parameter int AW = AMP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PW-1:0]        freq_word,
    output logic [PW-1:0]        phase,
    output logic signed [AW-1:0] rot_re,
    output logic signed [AW-1:0] rot_im
);
    logic [PW-1:0]           phase_q;
    logic                    run_q;
    logic [LUT_W-1:0]        idx;
    logic [1:0]              quad;
    logic [3:0]              fine;
    logic signed [AW-1:0]    s_a, s_b, sin_v, cos_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            run_q   <= 1'b0;
        end else begin
            phase_q <= phase_q + freq_word;
            run_q   <= 1'b1;
        end
    end

    assign phase = phase_q;
    assign idx   = phase_q[PW-1 -: LUT_W];
    assign quad  = idx[LUT_W-1 -: 2];
    assign fine  = idx[3:0];
    assign s_a   = quarter_sine(fine);
    assign s_b   = quarter_sine(~fine);

    always_comb begin
        case (quad)
            2'd0:    begin sin_v =  s_a; cos_v =  s_b; end
            2'd1:    begin sin_v =  s_b; cos_v = -s_a; end
            2'd2:    begin sin_v = -s_a; cos_v = -s_b; end
            default: begin sin_v = -s_b; cos_v =  s_a; end
        endcase
    end

    assign rot_re = cos_v;
    assign rot_im = -sin_v;

    // R2: phase advances by the held frequency word each cycle
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (phase == $past(phase) + $past(freq_word)));
endmodule

// File: rtl/carrier_handover.sv
module carrier_handover
    import carrier_ho_pkg::*;
#(
    parameter int EW = ERR_W,
    parameter int PW = PHASE_W,
    parameter int HW = HOLD_W,
    parameter int AW = AMP_W,
    localparam int SW = $clog2(PW)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 auto_en,
    input  logic                 timing_ok,
    input  logic signed [EW-1:0] nda_err,
    input  logic signed [EW-1:0] lock_metric,
    input  logic signed [EW-1:0] lock_thresh,
    input  logic [HW-1:0]        hold_len,
    input  logic signed [EW-1:0] dd_err,
    input  logic                 dd_stb,
    input  logic [SW-1:0]        kp_shift,
    input  logic [SW-1:0]        ki_shift,
    input  logic [PW-1:0]        init_freq,
    output logic [PW-1:0]        phase_o,
    output logic [PW-1:0]        freq_o,
    output logic signed [AW-1:0] rot_re,
    output logic signed [AW-1:0] rot_im,
    output logic                 locked_o,
    output logic                 track_o
);
    logic        locked;
    loop_mode_e  mode;
    err_sample_t upd;
    logic [PW-1:0] freq_w;

    ho_lock_detect #(.EW(EW), .HW(HW)) lock_i (
        .clk(clk), .rst(rst), .metric(lock_metric), .thresh(lock_thresh),
        .hold_len(hold_len), .locked(locked)
    );

    ho_mode_ctrl #(.EW(EW)) mode_i (
        .clk(clk), .rst(rst), .auto_en(auto_en), .locked(locked),
        .timing_ok(timing_ok), .nda_err(nda_err), .dd_err(dd_err),
        .dd_stb(dd_stb), .mode(mode), .upd(upd)
    );

    ho_loop_filter #(.EW(EW), .PW(PW)) filt_i (
        .clk(clk), .rst(rst), .upd(upd), .kp_shift(kp_shift),
        .ki_shift(ki_shift), .init_freq(init_freq), .freq_word(freq_w)
    );

    ho_nco #(.PW(PW), .AW(AW)) nco_i (
        .clk(clk), .rst(rst), .freq_word(freq_w), .phase(phase_o),
        .rot_re(rot_re), .rot_im(rot_im)
    );

    assign freq_o   = freq_w;
    assign locked_o = locked;
    assign track_o  = (mode == MODE_TRK);

    // R7: in tracking, no strobe means the frequency word holds
    assert_trk_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (track_o && !dd_stb) |=> $stable(freq_o));

    // R8: the switching edge is an ordinary acquisition step; phase stays continuous
    assert_switch_continuous_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(track_o) |-> (phase_o == $past(phase_o) + $past(freq_o)));
endmodule

// File: tb/carrier_handover_tb_top.sv
module carrier_handover_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        auto_en = 1'b0;
    logic        timing_ok = 1'b0;
    logic signed [15:0] nda_err = '0;
    logic signed [15:0] lock_metric = '0;
    logic signed [15:0] lock_thresh = '0;
    logic [15:0] hold_len = 16'd4;
    logic signed [15:0] dd_err = '0;
    logic        dd_stb = 1'b0;
    logic [4:0]  kp_shift = 5'd6;
    logic [4:0]  ki_shift = 5'd2;
    logic [31:0] init_freq = 32'h0100_0000;
    logic [31:0] phase_o, freq_o;
    logic signed [15:0] rot_re, rot_im;
    logic        locked_o, track_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench reference state
    logic [31:0] m_integ, m_ctrl, m_phase;
    int          m_cnt;
    bit          m_mode, m_prev_mode;

    always #2 clk = ~clk;   // 250 MHz

    carrier_handover dut_i (
        .clk(clk), .rst(rst), .auto_en(auto_en), .timing_ok(timing_ok),
        .nda_err(nda_err), .lock_metric(lock_metric), .lock_thresh(lock_thresh),
        .hold_len(hold_len), .dd_err(dd_err), .dd_stb(dd_stb),
        .kp_shift(kp_shift), .ki_shift(ki_shift), .init_freq(init_freq),
        .phase_o(phase_o), .freq_o(freq_o), .rot_re(rot_re), .rot_im(rot_im),
        .locked_o(locked_o), .track_o(track_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int need_len();
        return (hold_len == 0) ? 1 : int'(hold_len);
    endfunction

    function automatic logic [31:0] sx(input logic signed [15:0] e);
        return {{16{e[15]}}, e};
    endfunction

    // reference update for one clock edge, from the requirements
    task automatic model_edge();
        logic [31:0] e, ni, nphase;
        bit lk, nmode;
        lk = (m_cnt >= need_len());
        nphase = m_phase + m_ctrl;
        if (m_mode == 1'b0 || dd_stb) begin
            e  = sx(m_mode ? dd_err : nda_err);
            ni = m_integ + (e << ki_shift);
            m_ctrl  = ni + (e << kp_shift);
            m_integ = ni;
        end
        if (m_mode == 1'b0) nmode = auto_en && lk && timing_ok;
        else                nmode = auto_en;
        if (lock_metric > lock_thresh) begin
            if (m_cnt < need_len()) m_cnt++;
        end else begin
            m_cnt = 0;
        end
        m_prev_mode = m_mode;
        m_mode  = nmode;
        m_phase = nphase;
    endtask

    task automatic compare_all();
        real ang, er, ei;
        int  k, dre, dim;
        check("R2", phase_o, m_phase);
        if (m_prev_mode == 1'b0 && m_mode == 1'b1)
            check("R8", freq_o, m_ctrl);
        else if (m_prev_mode == 1'b0)
            check("R3", freq_o, m_ctrl);
        else
            check("R7", freq_o, m_ctrl);
        check("R4", {31'd0, locked_o}, {31'd0, (m_cnt >= need_len())});
        if (!auto_en)
            check("R5", {31'd0, track_o}, {31'd0, m_mode});
        else if (m_mode != m_prev_mode)
            check("R6", {31'd0, track_o}, {31'd0, m_mode});
        else
            check("R9", {31'd0, track_o}, {31'd0, m_mode});
        k   = int'(phase_o[31:26]);
        ang = (real'(k) + 0.5) * 2.0 * 3.14159265358979 / 64.0;
        er  = 32767.0 * $cos(ang);
        ei  = -32767.0 * $sin(ang);
        dre = int'(rot_re) - int'(er);
        dim = int'(rot_im) - int'(ei);
        checks++;
        if (dre > 4 || dre < -4 || dim > 4 || dim < -4) begin
            fails++;
            $display("FAIL R10: actual (%0d,%0d) expected (%0d,%0d)",
                     rot_re, rot_im, int'(er), int'(ei));
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    function automatic logic signed [15:0] rnd(input int span);
        return 16'(int'($urandom_range(2 * span)) - span);
    endfunction

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", phase_o, 32'd0);
        check("R1", freq_o, init_freq);
        check("R1", {31'd0, locked_o}, 32'd0);
        check("R1", {31'd0, track_o}, 32'd0);
        m_integ = init_freq; m_ctrl = init_freq; m_phase = '0;
        m_cnt = 0; m_mode = 1'b0; m_prev_mode = 1'b0;

        // R3/R5: acquisition with switch disabled, lock reached and held
        lock_thresh = 16'sd100; hold_len = 16'd5; timing_ok = 1'b1;
        for (int i = 0; i < 300; i++) begin
            nda_err = rnd(2000);
            lock_metric = (i % 50 == 7) ? 16'sd40 : 16'sd300;
            dd_stb = $urandom_range(1); dd_err = rnd(3000);
            step();
        end

        // R4: directed hold pattern, including the threshold value itself
        lock_metric = 16'sd0; step();
        for (int i = 0; i < 4; i++) begin lock_metric = 16'sd101; step(); end
        lock_metric = 16'sd100; step();
        for (int i = 0; i < 6; i++) begin lock_metric = 16'sd101; step(); end
        hold_len = 16'd0; lock_metric = -16'sd5; step();
        lock_metric = 16'sd200; step(); step();
        hold_len = 16'd5;

        // R6: enable set but timing unsettled, then settled
        auto_en = 1'b1; timing_ok = 1'b0; lock_metric = 16'sd300;
        for (int i = 0; i < 20; i++) begin nda_err = rnd(500); step(); end
        timing_ok = 1'b1;
        for (int i = 0; i < 3; i++) begin nda_err = rnd(500); step(); end

        // R7/R9: tracking with lost lock, dropped timing, ignored NDA error
        for (int i = 0; i < 400; i++) begin
            nda_err = rnd(20000);
            dd_err = rnd(1500);
            dd_stb = ($urandom_range(3) == 0);
            lock_metric = rnd(400);
            timing_ok = $urandom_range(1);
            step();
        end

        // R9: clearing the enable returns to acquisition
        auto_en = 1'b0;
        for (int i = 0; i < 10; i++) begin nda_err = rnd(500); step(); end

        // mixed random run, gains and enable toggling
        for (int i = 0; i < 2000; i++) begin
            if (i % 100 == 0) begin
                kp_shift = 5'($urandom_range(12));
                ki_shift = 5'($urandom_range(6));
                hold_len = 16'($urandom_range(8));
            end
            auto_en = ($urandom_range(15) != 0);
            timing_ok = ($urandom_range(3) != 0);
            lock_metric = rnd(300) + 16'sd120;
            nda_err = rnd(4000);
            dd_err = rnd(4000);
            dd_stb = ($urandom_range(3) == 0);
            step();
        end

        // R1: reset mid-run with a new seed frequency
        init_freq = 32'hFF80_0000; rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        check("R1", phase_o, 32'd0);
        check("R1", freq_o, init_freq);
        check("R1", {31'd0, track_o}, 32'd0);
        m_integ = init_freq; m_ctrl = init_freq; m_phase = '0;
        m_cnt = 0; m_mode = 1'b0; m_prev_mode = 1'b0;
        for (int i = 0; i < 200; i++) begin nda_err = rnd(100); step(); end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule